// File: doc/BRIEF.md
# Per-Source Virtual-Queue Transit Buffer

This block is the low-priority transit buffer at one crosspoint of a column of crosspoint buffers. Cells arrive from the crosspoint above. Each cell carries a source-port tag that names the upstream input it came from. The buffer keeps one FIFO queue for each upstream source and sorts every arriving cell into the queue that its tag names.

Each queue raises its own request line while it holds a cell, and it shows its head cell on a dedicated output slice. An external ring arbiter grants one or more queues by pulsing their pop lines, and each granted queue then releases its head cell. The buffer also counts how many cells it holds in total. When that count comes close to capacity, it raises a backpressure flag toward the upstream controller, which leaves room for cells that are already on their way. A cell with a tag that names no queue is discarded, and an error pulse reports the drop.

Top module: `srcq_transit_buf`

## Requirements
- R1: With crosspoint index parameter XPOS (default 5) there are XPOS-1 queues, numbered 1 to XPOS-1. A cell presented with `in_valid` high and `in_id` equal to i, where 1 ≤ i ≤ XPOS-1, is stored in queue i and in no other queue. Queue i uses bit i-1 of `req` and `pop` and slice i-1 of `head_data`, where slice q is bits [q*DATA_W +: DATA_W].
- R2: Each queue delivers its cells in the order they were written, and its oldest cell always appears on its `head_data` slice.
- R3: `req[i-1]` is high exactly when queue i holds at least one cell. The flag changes on the clock edge that stores or removes the cell.
- R4: A pulse on `pop[i-1]` while queue i holds cells removes its head cell at the clock edge. A pop of an empty queue has no effect.
- R5: A write and a pop may reach the same queue in the same cycle. If the queue holds cells, both take effect and its occupancy does not change. If the queue is empty, the write is accepted and the pop is ignored.
- R6: Each queue holds at most DEPTH cells (default 4). A write to a full queue that is not popped in the same cycle is discarded, and the queue's contents and order stay as they were.
- R7: `nack_lo` is high exactly when the total number of stored cells is at least (XPOS-1)·DEPTH − NF_MARGIN, where NF_MARGIN defaults to 2. It is evaluated on the registered occupancy.
- R8: A valid cell with `in_id` equal to 0 or at least XPOS is not stored in any queue, and `id_err` is high for the one cycle that follows the clock edge at which that cell was presented.
- R9: After reset all queues are empty, and `req`, `nack_lo` and `id_err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An arriving cell is present |
| in_id | input | ID_W | Source-port tag of the arriving cell |
| in_data | input | DATA_W | Payload of the arriving cell |
| pop | input | XPOS-1 | Per-queue grant; removes that queue's head cell |
| req | output | XPOS-1 | Per-queue request, high while the queue holds a cell |
| head_data | output | (XPOS-1)*DATA_W | Head cell of every queue, one slice per queue |
| nack_lo | output | 1 | Near-full backpressure toward the upstream controller |
| id_err | output | 1 | One-cycle pulse after a cell with an out-of-range tag |

## Verification
The bench drives every tag value from 0 to 7. A design that decodes the tag with an off-by-one error would send cells to the neighbouring queue, or keep cells tagged 0 or 5 and above instead of dropping them. Each queue is filled past its depth and then popped while full. A design that overwrote the head on overflow, or that ignored a write arriving together with a pop, would break the order check or miss a cell. The bench also pops empty queues, writes to an empty queue that is popped in the same cycle, and walks the total occupancy across the near-full threshold in both directions. These cases expose a wrong counter underflow, a lost first cell, or a backpressure flag set at the wrong level. A long pseudo-random run of mixed writes and multi-queue pops is then compared against an arithmetic model of each queue.

// File: rtl/srcq_pkg.sv
package srcq_pkg;

  // True when a source tag names an existing virtual queue.
  function automatic logic id_in_range(input int unsigned id, input int unsigned xpos);
    return (id >= 1) && (id < xpos);
  endfunction

  // Occupancy level at which backpressure is raised.
  function automatic int unsigned nf_threshold(input int unsigned nq,
                                               input int unsigned depth,
                                               input int unsigned margin);
    int unsigned cap;
    cap = nq * depth;
    return (margin >= cap) ? 0 : cap - margin;
  endfunction

  // Circular pointer advance for a ring of 'depth' slots.
  function automatic int unsigned ring_next(input int unsigned ptr, input int unsigned depth);
    return (ptr + 1 >= depth) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/srcq_demux.sv
module srcq_demux
  import srcq_pkg::*;
#(
  parameter int XPOS = 5,
  parameter int ID_W = 3,
  localparam int NQ  = XPOS - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [ID_W-1:0] in_id,
  output logic [NQ-1:0]   wr_vec,
  output logic            bad_id
);

  for (genvar g = 0; g < NQ; g++) begin : g_dec
    assign wr_vec[g] = in_valid && (in_id == ID_W'(g + 1));
  end

  assign bad_id = in_valid && !id_in_range(int'(in_id), XPOS);

  assert_one_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec));

  assert_bad_unrouted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_id |-> (wr_vec == '0));

  assert_valid_routed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !bad_id) |-> ($countones(wr_vec) == 1));

endmodule

// File: rtl/srcq_vq.sv
module srcq_vq
  import srcq_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              nonempty,
  output logic              acc_wr,
  output logic              acc_pop,
  output logic [CNT_W-1:0]  cnt
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              full;

  assign full     = (cnt == CNT_W'(DEPTH));
  assign nonempty = (cnt != '0);
  assign acc_pop  = pop && nonempty;
  assign acc_wr   = wr_en && (!full || acc_pop);
  assign head     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (acc_wr)  wr_ptr <= PTR_W'(ring_next(int'(wr_ptr), DEPTH));
      if (acc_pop) rd_ptr <= PTR_W'(ring_next(int'(rd_ptr), DEPTH));
      case ({acc_wr, acc_pop})
        2'b10:   cnt <= cnt + CNT_W'(1);
        2'b01:   cnt <= cnt - CNT_W'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (acc_wr) mem[wr_ptr] <= wr_data;
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));

  assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !pop) |=> (cnt == CNT_W'(DEPTH)));

  assert_pop_shrinks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && nonempty && !wr_en) |=> (cnt == $past(cnt) - CNT_W'(1)));

  assert_empty_pop_noop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !nonempty && !wr_en) |=> (cnt == '0));

  assert_wr_pop_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && pop && nonempty) |=> (cnt == $past(cnt)));

  assert_empty_wr_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && pop && !nonempty) |=> (cnt == CNT_W'(1)));

endmodule

// File: rtl/srcq_occ.sv
module srcq_occ
  import srcq_pkg::*;
#(
  parameter int NQ        = 4,
  parameter int DEPTH     = 4,
  parameter int NF_MARGIN = 2,
  localparam int CAP      = NQ * DEPTH,
  localparam int TOT_W    = $clog2(CAP + 1),
  localparam int THRESH   = nf_threshold(NQ, DEPTH, NF_MARGIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NQ-1:0]    acc_wr,
  input  logic [NQ-1:0]    acc_pop,
  output logic [TOT_W-1:0] total,
  output logic             nack_lo
);

  logic [TOT_W-1:0] n_wr, n_pop;

  always_comb begin
    n_wr  = '0;
    n_pop = '0;
    for (int q = 0; q < NQ; q++) begin
      n_wr  = n_wr  + TOT_W'(acc_wr[q]);
      n_pop = n_pop + TOT_W'(acc_pop[q]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) total <= '0;
    else        total <= total + n_wr - n_pop;
  end

  assign nack_lo = (total >= TOT_W'(THRESH));

  assert_total_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    total <= TOT_W'(CAP));

  assert_nack_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack_lo) |-> ($past(n_wr) > $past(n_pop)));

endmodule

// File: rtl/srcq_transit_buf.sv
module srcq_transit_buf
  import srcq_pkg::*;
#(
  parameter int XPOS      = 5,
  parameter int DEPTH     = 4,
  parameter int DATA_W    = 16,
  parameter int ID_W      = 3,
  parameter int NF_MARGIN = 2,
  localparam int NQ       = XPOS - 1,
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int TOT_W    = $clog2(NQ * DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [ID_W-1:0]      in_id,
  input  logic [DATA_W-1:0]    in_data,
  input  logic [NQ-1:0]        pop,
  output logic [NQ-1:0]        req,
  output logic [NQ*DATA_W-1:0] head_data,
  output logic                 nack_lo,
  output logic                 id_err
);

  logic [NQ-1:0]       wr_vec;
  logic                bad_id;
  logic [NQ-1:0]       q_acc_wr, q_acc_pop;
  logic [CNT_W-1:0]    q_cnt [NQ];
  logic [TOT_W-1:0]    total;
  logic [TOT_W-1:0]    cnt_sum;

  srcq_demux #(.XPOS(XPOS), .ID_W(ID_W)) u_demux (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_id(in_id),
    .wr_vec(wr_vec), .bad_id(bad_id)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_vq
    srcq_vq #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_vq (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_vec[q]), .wr_data(in_data), .pop(pop[q]),
      .head(head_data[q*DATA_W +: DATA_W]), .nonempty(req[q]),
      .acc_wr(q_acc_wr[q]), .acc_pop(q_acc_pop[q]), .cnt(q_cnt[q])
    );
  end

  srcq_occ #(.NQ(NQ), .DEPTH(DEPTH), .NF_MARGIN(NF_MARGIN)) u_occ (
    .clk(clk), .rst_n(rst_n), .acc_wr(q_acc_wr), .acc_pop(q_acc_pop),
    .total(total), .nack_lo(nack_lo)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) id_err <= 1'b0;
    else        id_err <= bad_id;
  end

  always_comb begin
    cnt_sum = '0;
    for (int q = 0; q < NQ; q++) cnt_sum = cnt_sum + TOT_W'(q_cnt[q]);
  end

  assert_total_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
    total == cnt_sum);

  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !id_in_range(int'(in_id), XPOS)) |=> id_err);

  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && !id_in_range(int'(in_id), XPOS)) |=> !id_err);

  assert_reset_clear_R9: assert property (@(posedge clk)
    !rst_n |=> (req == '0 && !id_err && !nack_lo));

endmodule

// File: tb/srcq_transit_buf_tb.sv
module srcq_transit_buf_tb;
  localparam int NQ = 4;
  localparam int DEPTH = 4;
  localparam int DW = 16;
  localparam int THR = NQ * DEPTH - 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] in_id = '0;
  logic [DW-1:0] in_data = '0;
  logic [NQ-1:0] pop = '0;
  logic [NQ-1:0] req;
  logic [NQ*DW-1:0] head_data;
  logic nack_lo, id_err;

  int checks = 0;
  int fails = 0;
  logic [DW-1:0] mq [NQ][$];
  logic exp_err = 1'b0;

  always #5 clk = ~clk;

  srcq_transit_buf u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_id(in_id), .in_data(in_data),
    .pop(pop), .req(req), .head_data(head_data), .nack_lo(nack_lo), .id_err(id_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int total_cells();
    int t = 0;
    for (int q = 0; q < NQ; q++) t += mq[q].size();
    return t;
  endfunction

  task automatic check_all();
    for (int q = 0; q < NQ; q++) begin
      chk($sformatf("R3 req[%0d]", q), int'(req[q]), int'(mq[q].size() > 0));
      if (mq[q].size() > 0)
        chk($sformatf("R2 head[%0d]", q), int'(head_data[q*DW +: DW]), int'(mq[q][0]));
    end
    chk("R7 nack_lo", int'(nack_lo), int'(total_cells() >= THR));
    chk("R8 id_err", int'(id_err), int'(exp_err));
  endtask

  task automatic step(input logic v, input logic [2:0] id, input logic [DW-1:0] d,
                      input logic [NQ-1:0] p);
    logic popok [NQ];
    @(negedge clk);
    in_valid = v; in_id = id; in_data = d; pop = p;
    exp_err = v && (id == 0 || id >= 5);
    for (int q = 0; q < NQ; q++) popok[q] = p[q] && (mq[q].size() > 0);
    for (int q = 0; q < NQ; q++) begin
      logic wr;
      wr = v && (int'(id) == q + 1) && (mq[q].size() < DEPTH || popok[q]);
      if (popok[q]) void'(mq[q].pop_front());
      if (wr) mq[q].push_back(d);
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0; pop = '0;
    check_all();
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    chk("R9 req after reset", int'(req), 0);
    chk("R9 nack after reset", int'(nack_lo), 0);
    chk("R9 id_err after reset", int'(id_err), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1, R8: sweep of every tag value
    for (int id = 0; id < 8; id++) step(1'b1, 3'(id), 16'(16'h100 + id), '0);
    for (int q = 1; q <= NQ; q++)
      chk($sformatf("R1 tag %0d lands in queue %0d", q, q), int'(mq[q-1].size()), 1);

    // R4: drain, then pop empties
    for (int q = 0; q < NQ; q++) step(1'b0, '0, '0, NQ'(1 << q));
    for (int q = 0; q < NQ; q++) step(1'b0, '0, '0, NQ'(1 << q));
    chk("R4 empty after pops", int'(req), 0);

    // R6, R7: overfill each queue, crossing the near-full level
    for (int q = 0; q < NQ; q++)
      for (int n = 0; n < DEPTH + 2; n++) step(1'b1, 3'(q + 1), 16'((q << 8) | n), '0);
    chk("R6 total capped", total_cells(), NQ * DEPTH);

    // R5: write and pop on a full queue
    step(1'b1, 3'd1, 16'hBEEF, 4'b0001);
    chk("R5 full queue keeps depth", int'(mq[0].size()), DEPTH);

    // R4, R7: multi-queue drain past threshold, and pops of empty queues
    repeat (DEPTH + 2) step(1'b0, '0, '0, 4'b1111);

    // R5: write plus pop on an empty queue
    step(1'b1, 3'd2, 16'h5A5A, 4'b0010);
    chk("R5 empty write accepted", int'(req[1]), 1);
    step(1'b0, '0, '0, 4'b0010);

    // Mixed pseudo-random traffic
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[5], lfsr[3:1], lfsr ^ 16'(i),
           (i % 3 == 0) ? lfsr[11:8] : lfsr[11:8] & lfsr[15:12]);
    end

    // R9: reset clears a loaded buffer
    step(1'b1, 3'd3, 16'h1234, '0);
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    chk("R9 req cleared", int'(req), 0);
    chk("R9 nack cleared", int'(nack_lo), 0);
    finish_run();
  end
endmodule